// File: doc/BRIEF.md
# SD Card Identification Sequencer

This block takes a freshly powered SD card from its idle state to the selected transfer state. It needs no processor. It drives a separate command/response engine through a fixed series of commands. For each command the sequencer issues one request with a command index, a 32-bit argument and an expected response kind. The engine reports completion with an error flag and up to 128 bits of response data. Bit-level framing and CRC belong to the engine, not to this block.

A single `start_i` pulse launches the sequence:

1. A reset command, then a settle delay.
2. An interface-condition probe that decides whether the card follows version 2 of the protocol.
3. An application-prefix / operating-condition polling loop, bounded by a deadline.
4. The identity read.
5. The address assignment. After it, the SD clock divider switches from the slow identification rate to full speed.
6. The card-specific data read.
7. The select command, then a wait for the busy line to release.

When the sequence ends, the block holds the relative card address, the high-capacity flag and both 128-bit registers for the data path. The high-capacity flag tells later data commands whether block addresses must be shifted left by 9 to form byte addresses. Every abort leaves its own error code, and a good run ends in a one-cycle `done_o` pulse. All delays are counted in bus-clock cycles and set by parameters.

Top module: `sd_ident_seq`

## Requirements
- R1: After reset the block is idle: `cmd_valid_o`=0, `done_o`=0, `err_code_o`=0, `clk_div_o`=0x07D, `rca_o`=0 and `hc_o`=0.
- R2: `start_i` in the idle state issues index 0, argument 0, response kind 0 (none). An error from the engine ends the run with code 0x3F (−1). On success the next request comes no sooner than IDLE_WAIT_CYC+1 cycles after the completion cycle. While a request is outstanding no new request is issued and its index and argument stay stable.
- R3: The probe uses index 8, argument 0x1AA and response kind 6. The card counts as version 2 only if the probe completes without error and response bits [11:0] equal 0x1AA. A probe error does not abort the run.
- R4: Each poll issues index 55 (argument = RCA<<16, which is 0 here, kind 1), then index 41 (kind 4, argument 0x00FF8000 with bit 30 set only for a version-2 card). Polling repeats until response bit 31 of index 41 is 1.
- R5: Before each index-55 request the block checks whether INIT_TMO_CYC cycles have passed since the probe completed. If so, it aborts with 0x3E (−2) and issues no further request.
- R6: An engine error on index 55 aborts with 0x3D (−3), and on index 41 with 0x3C (−4).
- R7: `hc_o` takes bit 30 of the final index-41 response, the one with bit 31 set.
- R8: Index 2 (argument 0, kind 3) loads `cid_o` with all 128 response bits; bits [127:96] hold the first, most significant word. An error gives 0x3B (−5).
- R9: Index 3 (argument 0, kind 5) loads `rca_o` from response bits [31:16]. On success `clk_div_o` becomes 0x001, and it stays 0x07D until then. An error gives 0x3A (−6).
- R10: Index 9 (argument RCA<<16, kind 3) loads `csd_o`. An error gives 0x35 (−11).
- R11: Index 7 (argument RCA<<16, kind 2) selects the card. An error gives 0x2C (−20).
- R12: After index 7, once `card_busy_i` is low, `done_o` pulses for exactly one cycle with `err_code_o`=0. If `card_busy_i` stays high past BUSY_TMO_CYC cycles, the run aborts with 0x2B (−21) and `done_o` stays low.
- R13: `start_i` while a run is in progress has no effect: no second reset command is issued and the run completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a sequence when idle |
| cmd_valid_o | output | 1 | One-cycle command request |
| cmd_idx_o | output | 6 | Command index |
| cmd_arg_o | output | 32 | Command argument |
| cmd_rsp_o | output | 3 | Expected response kind (0 none, 1 R1, 2 R1b, 3 R2, 4 R3, 5 R6, 6 R7) |
| cmd_done_i | input | 1 | Engine completion pulse |
| cmd_err_i | input | 1 | Engine error, valid with cmd_done_i |
| cmd_rsp_data_i | input | 128 | Response data; short responses in [31:0] |
| card_busy_i | input | 1 | Card busy line, high while busy |
| clk_div_o | output | 11 | SD clock divider |
| done_o | output | 1 | One-cycle pulse when the card is selected |
| err_code_o | output | 6 | Two's-complement abort code, 0 when clean |
| rca_o | output | 16 | Relative card address |
| hc_o | output | 1 | High-capacity card flag |
| cid_o | output | 128 | Card identity register |
| csd_o | output | 128 | Card-specific data register |

## Verification
A wrong step register appears at the very next request as a wrong index, argument or response kind. A wrong phase appears as a request issued while another is outstanding, or as a missing request. Both are caught in the cycle the request is sampled. A wrong version-2 decision shows on bit 30 of the first operating-condition argument, two requests after the probe. A wrong divider switch is visible on `clk_div_o` at the next request. Timer faults show as an early request after the reset command, or as an abort code arriving before its cycle budget has been spent.

// File: rtl/sdid_pkg.sv
package sdid_pkg;
  localparam int IDX_W = 6;
  localparam int ARG_W = 32;
  localparam int RSP_W = 128;
  localparam int DIV_W = 11;
  localparam int ERR_W = 6;
  localparam int RCA_W = 16;
  localparam int ECHO_W = 12;

  localparam logic [DIV_W-1:0]  DIV_IDENT  = 11'h07D;
  localparam logic [DIV_W-1:0]  DIV_XFER   = 11'h001;
  localparam logic [ECHO_W-1:0] IF_PATTERN = 12'h1AA;
  localparam logic [ARG_W-1:0]  OCR_WINDOW = 32'h00FF_8000;

  localparam logic [ERR_W-1:0] ERR_NONE     = 6'h00;
  localparam logic [ERR_W-1:0] ERR_LOOP_TMO = 6'h3E;
  localparam logic [ERR_W-1:0] ERR_BUSY_TMO = 6'h2B;

  typedef enum logic [2:0] {
    RSP_NONE = 3'd0, RSP_R1 = 3'd1, RSP_R1B = 3'd2, RSP_R2 = 3'd3,
    RSP_R3 = 3'd4, RSP_R6 = 3'd5, RSP_R7 = 3'd6
  } rsp_kind_e;

  typedef enum logic [2:0] {
    ST_GO_IDLE, ST_IF_COND, ST_APP_PFX, ST_OP_COND,
    ST_GET_CID, ST_GET_RCA, ST_GET_CSD, ST_SELECT
  } step_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SEND, PH_WAIT, PH_SETTLE, PH_LOOP_CHK, PH_BUSY
  } phase_e;

  typedef enum logic [1:0] {
    LIM_SETTLE, LIM_LOOP, LIM_BUSY
  } lim_sel_e;

  function automatic logic [IDX_W-1:0] step_index(step_e s);
    case (s)
      ST_GO_IDLE: return 6'd0;
      ST_IF_COND: return 6'd8;
      ST_APP_PFX: return 6'd55;
      ST_OP_COND: return 6'd41;
      ST_GET_CID: return 6'd2;
      ST_GET_RCA: return 6'd3;
      ST_GET_CSD: return 6'd9;
      default:    return 6'd7;
    endcase
  endfunction

  function automatic rsp_kind_e step_rsp(step_e s);
    case (s)
      ST_GO_IDLE: return RSP_NONE;
      ST_IF_COND: return RSP_R7;
      ST_APP_PFX: return RSP_R1;
      ST_OP_COND: return RSP_R3;
      ST_GET_CID: return RSP_R2;
      ST_GET_RCA: return RSP_R6;
      ST_GET_CSD: return RSP_R2;
      default:    return RSP_R1B;
    endcase
  endfunction

  function automatic logic [ERR_W-1:0] step_err(step_e s);
    case (s)
      ST_GO_IDLE: return 6'h3F;
      ST_APP_PFX: return 6'h3D;
      ST_OP_COND: return 6'h3C;
      ST_GET_CID: return 6'h3B;
      ST_GET_RCA: return 6'h3A;
      ST_GET_CSD: return 6'h35;
      ST_SELECT:  return 6'h2C;
      default:    return ERR_NONE;
    endcase
  endfunction

  function automatic logic [ARG_W-1:0] step_arg(step_e s, logic v2, logic [RCA_W-1:0] rca);
    logic [ARG_W-1:0] addr_arg;
    addr_arg = {rca, {(ARG_W-RCA_W){1'b0}}};
    case (s)
      ST_IF_COND: return {{(ARG_W-ECHO_W){1'b0}}, IF_PATTERN};
      ST_APP_PFX: return addr_arg;
      ST_OP_COND: return OCR_WINDOW | {1'b0, v2, 30'd0};
      ST_GET_CSD: return addr_arg;
      ST_SELECT:  return addr_arg;
      default:    return '0;
    endcase
  endfunction

  function automatic logic echo_match(logic [ECHO_W-1:0] echo);
    return echo == IF_PATTERN;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/sdid_timer.sv
module sdid_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  // Saturating up-counter; cleared whenever a timed phase is entered.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr)           cnt_q <= '0;
    else if (cnt_q < limit) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q >= limit);
endmodule

// File: rtl/sdid_store.sv
module sdid_store import sdid_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             ld_v2,
  input  logic             v2_val,
  input  logic             ld_hc,
  input  logic             ld_rca,
  input  logic             ld_cid,
  input  logic             ld_csd,
  input  logic             ld_fast,
  input  logic             ld_err,
  input  logic [ERR_W-1:0] err_val,
  input  logic [RSP_W-1:0] rsp,
  output logic             v2_o,
  output logic             hc_o,
  output logic [RCA_W-1:0] rca_o,
  output logic [RSP_W-1:0] cid_o,
  output logic [RSP_W-1:0] csd_o,
  output logic [DIV_W-1:0] div_o,
  output logic [ERR_W-1:0] err_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2_o  <= 1'b0;
      hc_o  <= 1'b0;
      rca_o <= '0;
      div_o <= DIV_IDENT;
      err_o <= ERR_NONE;
    end else if (clr_all) begin
      v2_o  <= 1'b0;
      hc_o  <= 1'b0;
      rca_o <= '0;
      div_o <= DIV_IDENT;
      err_o <= ERR_NONE;
    end else begin
      if (ld_v2)   v2_o  <= v2_val;
      if (ld_hc)   hc_o  <= rsp[30];
      if (ld_rca)  rca_o <= rsp[31:16];
      if (ld_fast) div_o <= DIV_XFER;
      if (ld_err)  err_o <= err_val;
    end
  end

  // Long registers are kept across runs until the next capture.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cid_o <= '0;
      csd_o <= '0;
    end else begin
      if (ld_cid) cid_o <= rsp;
      if (ld_csd) csd_o <= rsp;
    end
  end
endmodule

// File: rtl/sdid_ctrl.sv
module sdid_ctrl import sdid_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmd_done_i,
  input  logic             cmd_err_i,
  input  logic             ocr_ready,
  input  logic             echo_ok,
  input  logic             card_busy_i,
  input  logic             tmr_expired,
  input  logic             v2,
  input  logic [RCA_W-1:0] rca,
  output logic             tmr_clr,
  output lim_sel_e         lim_sel,
  output logic             cmd_valid,
  output logic [IDX_W-1:0] cmd_idx,
  output logic [ARG_W-1:0] cmd_arg,
  output rsp_kind_e        cmd_kind,
  output logic             clr_all,
  output logic             ld_v2,
  output logic             v2_val,
  output logic             ld_hc,
  output logic             ld_rca,
  output logic             ld_cid,
  output logic             ld_csd,
  output logic             ld_fast,
  output logic             ld_err,
  output logic [ERR_W-1:0] err_val,
  output logic             done,
  output logic             in_wait
);
  phase_e phase_q, phase_d;
  step_e  step_q, step_d;
  logic   done_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= ST_GO_IDLE;
      done    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      done    <= done_d;
    end
  end

  always_comb begin
    phase_d = phase_q;
    step_d  = step_q;
    tmr_clr = 1'b0;
    clr_all = 1'b0;
    ld_v2   = 1'b0;
    v2_val  = 1'b0;
    ld_hc   = 1'b0;
    ld_rca  = 1'b0;
    ld_cid  = 1'b0;
    ld_csd  = 1'b0;
    ld_fast = 1'b0;
    ld_err  = 1'b0;
    err_val = ERR_NONE;
    done_d  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          clr_all = 1'b1;
          step_d  = ST_GO_IDLE;
          phase_d = PH_SEND;
        end
      end
      PH_SEND: phase_d = PH_WAIT;
      PH_WAIT: begin
        if (cmd_done_i) begin
          if (cmd_err_i && step_q != ST_IF_COND) begin
            ld_err  = 1'b1;
            err_val = step_err(step_q);
            phase_d = PH_IDLE;
          end else begin
            case (step_q)
              ST_GO_IDLE: begin
                tmr_clr = 1'b1;
                phase_d = PH_SETTLE;
              end
              ST_IF_COND: begin
                ld_v2   = 1'b1;
                v2_val  = !cmd_err_i && echo_ok;
                tmr_clr = 1'b1;
                step_d  = ST_APP_PFX;
                phase_d = PH_LOOP_CHK;
              end
              ST_APP_PFX: begin
                step_d  = ST_OP_COND;
                phase_d = PH_SEND;
              end
              ST_OP_COND: begin
                if (ocr_ready) begin
                  ld_hc   = 1'b1;
                  step_d  = ST_GET_CID;
                  phase_d = PH_SEND;
                end else begin
                  step_d  = ST_APP_PFX;
                  phase_d = PH_LOOP_CHK;
                end
              end
              ST_GET_CID: begin
                ld_cid  = 1'b1;
                step_d  = ST_GET_RCA;
                phase_d = PH_SEND;
              end
              ST_GET_RCA: begin
                ld_rca  = 1'b1;
                ld_fast = 1'b1;
                step_d  = ST_GET_CSD;
                phase_d = PH_SEND;
              end
              ST_GET_CSD: begin
                ld_csd  = 1'b1;
                step_d  = ST_SELECT;
                phase_d = PH_SEND;
              end
              default: begin
                tmr_clr = 1'b1;
                phase_d = PH_BUSY;
              end
            endcase
          end
        end
      end
      PH_SETTLE: begin
        if (tmr_expired) begin
          step_d  = ST_IF_COND;
          phase_d = PH_SEND;
        end
      end
      PH_LOOP_CHK: begin
        if (tmr_expired) begin
          ld_err  = 1'b1;
          err_val = ERR_LOOP_TMO;
          phase_d = PH_IDLE;
        end else begin
          phase_d = PH_SEND;
        end
      end
      PH_BUSY: begin
        if (!card_busy_i) begin
          done_d  = 1'b1;
          phase_d = PH_IDLE;
        end else if (tmr_expired) begin
          ld_err  = 1'b1;
          err_val = ERR_BUSY_TMO;
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    case (phase_q)
      PH_SETTLE: lim_sel = LIM_SETTLE;
      PH_BUSY:   lim_sel = LIM_BUSY;
      default:   lim_sel = LIM_LOOP;
    endcase
  end

  assign cmd_valid = (phase_q == PH_SEND);
  assign in_wait   = (phase_q == PH_WAIT);
  assign cmd_idx   = step_index(step_q);
  assign cmd_kind  = step_rsp(step_q);
  assign cmd_arg   = step_arg(step_q, v2, rca);
endmodule

// File: rtl/sd_ident_seq.sv
module sd_ident_seq import sdid_pkg::*; #(
  parameter int unsigned IDLE_WAIT_CYC = 50_000,
  parameter int unsigned INIT_TMO_CYC  = 50_000_000,
  parameter int unsigned BUSY_TMO_CYC  = 250_000_000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  output logic         cmd_valid_o,
  output logic [5:0]   cmd_idx_o,
  output logic [31:0]  cmd_arg_o,
  output logic [2:0]   cmd_rsp_o,
  input  logic         cmd_done_i,
  input  logic         cmd_err_i,
  input  logic [127:0] cmd_rsp_data_i,
  input  logic         card_busy_i,
  output logic [10:0]  clk_div_o,
  output logic         done_o,
  output logic [5:0]   err_code_o,
  output logic [15:0]  rca_o,
  output logic         hc_o,
  output logic [127:0] cid_o,
  output logic [127:0] csd_o
);
  localparam int unsigned MAX_LIM = max3(IDLE_WAIT_CYC, INIT_TMO_CYC, BUSY_TMO_CYC);
  localparam int CNT_W = $clog2(MAX_LIM + 1);

  // Named internal events, brought out for the checker.
  logic             ev_in_wait;
  logic             ev_v2;
  logic             tmr_clr, tmr_expired;
  lim_sel_e         lim_sel;
  logic [CNT_W-1:0] tmr_limit;
  rsp_kind_e        cmd_kind;
  logic             clr_all, ld_v2, v2_val, ld_hc, ld_rca, ld_cid, ld_csd, ld_fast, ld_err;
  logic [ERR_W-1:0] err_val;
  logic             ocr_ready, echo_ok;

  assign ocr_ready = cmd_rsp_data_i[31];
  assign echo_ok   = echo_match(cmd_rsp_data_i[ECHO_W-1:0]);

  always_comb begin
    case (lim_sel)
      LIM_SETTLE: tmr_limit = CNT_W'(IDLE_WAIT_CYC);
      LIM_BUSY:   tmr_limit = CNT_W'(BUSY_TMO_CYC);
      default:    tmr_limit = CNT_W'(INIT_TMO_CYC);
    endcase
  end

  sdid_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tmr_clr),
    .limit   (tmr_limit),
    .expired (tmr_expired)
  );

  sdid_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cmd_done_i  (cmd_done_i),
    .cmd_err_i   (cmd_err_i),
    .ocr_ready   (ocr_ready),
    .echo_ok     (echo_ok),
    .card_busy_i (card_busy_i),
    .tmr_expired (tmr_expired),
    .v2          (ev_v2),
    .rca         (rca_o),
    .tmr_clr     (tmr_clr),
    .lim_sel     (lim_sel),
    .cmd_valid   (cmd_valid_o),
    .cmd_idx     (cmd_idx_o),
    .cmd_arg     (cmd_arg_o),
    .cmd_kind    (cmd_kind),
    .clr_all     (clr_all),
    .ld_v2       (ld_v2),
    .v2_val      (v2_val),
    .ld_hc       (ld_hc),
    .ld_rca      (ld_rca),
    .ld_cid      (ld_cid),
    .ld_csd      (ld_csd),
    .ld_fast     (ld_fast),
    .ld_err      (ld_err),
    .err_val     (err_val),
    .done        (done_o),
    .in_wait     (ev_in_wait)
  );

  assign cmd_rsp_o = cmd_kind;

  sdid_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_all (clr_all),
    .ld_v2   (ld_v2),
    .v2_val  (v2_val),
    .ld_hc   (ld_hc),
    .ld_rca  (ld_rca),
    .ld_cid  (ld_cid),
    .ld_csd  (ld_csd),
    .ld_fast (ld_fast),
    .ld_err  (ld_err),
    .err_val (err_val),
    .rsp     (cmd_rsp_data_i),
    .v2_o    (ev_v2),
    .hc_o    (hc_o),
    .rca_o   (rca_o),
    .cid_o   (cid_o),
    .csd_o   (csd_o),
    .div_o   (clk_div_o),
    .err_o   (err_code_o)
  );
endmodule

// File: rtl/sd_ident_seq_chk.sv
module sd_ident_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid_o,
  input logic [5:0]  cmd_idx_o,
  input logic [31:0] cmd_arg_o,
  input logic [10:0] clk_div_o,
  input logic        done_o,
  input logic [5:0]  err_code_o,
  input logic [15:0] rca_o,
  input logic        in_wait,
  input logic        card_v2
);
  logic [5:0] last_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           last_idx <= 6'h3F;
    else if (cmd_valid_o) last_idx <= cmd_idx_o;
  end

  AST_NO_REQ_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !cmd_valid_o); // R2
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && $past(in_wait)) |-> ($stable(cmd_idx_o) && $stable(cmd_arg_o))); // R2
  AST_OPCOND_ARG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_idx_o == 6'd41) |-> (cmd_arg_o[30] == card_v2 && cmd_arg_o[23:15] == 9'h1FF)); // R4
  AST_APP_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_idx_o == 6'd41) |-> last_idx == 6'd55); // R4
  AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_div_o == 11'h07D) || (clk_div_o == 11'h001)); // R9
  AST_SLOW_IN_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_idx_o == 6'd55) |-> clk_div_o == 11'h07D); // R9
  AST_FAST_AFTER_RCA: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_idx_o == 6'd9) |-> clk_div_o == 11'h001); // R9
  AST_SELECT_ARG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_idx_o == 6'd7) |-> cmd_arg_o[31:16] == rca_o); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R12
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (err_code_o == 6'h00 && clk_div_o == 11'h001)); // R12
endmodule

bind sd_ident_seq sd_ident_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid_o (cmd_valid_o),
  .cmd_idx_o   (cmd_idx_o),
  .cmd_arg_o   (cmd_arg_o),
  .clk_div_o   (clk_div_o),
  .done_o      (done_o),
  .err_code_o  (err_code_o),
  .rca_o       (rca_o),
  .in_wait     (ev_in_wait),
  .card_v2     (ev_v2)
);

// File: tb/sd_ident_seq_bench.sv
module sd_ident_seq_bench;
  localparam int IDLE_W = 20;
  localparam int INIT_T = 400;
  localparam int BUSY_T = 100;
  localparam logic [15:0]  RCA_V   = 16'hB5C3;
  localparam logic [127:0] CID_PAT = 128'h0351_4453_5531_3647_8012_3456_7801_2345;
  localparam logic [127:0] CSD_PAT = 128'h400E_0032_5B59_0000_EDC8_7F80_0A40_4067;

  typedef struct packed {
    logic [5:0]  fail;    // index that returns an engine error, 0x3F = none
    logic [11:0] echo;
    logic [7:0]  nready;  // not-ready polls before ready, 255 = never
    logic        ocr30;
    logic [7:0]  busy;    // busy cycles after select, 255 = forever
    logic [5:0]  exp_err;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{6'h3F, 12'h1AA, 8'd2, 1'b1, 8'd5,   6'h00},
    '{6'd8,  12'h1AA, 8'd0, 1'b0, 8'd0,   6'h00},
    '{6'h3F, 12'h0AA, 8'd1, 1'b0, 8'd3,   6'h00},
    '{6'd0,  12'h1AA, 8'd0, 1'b0, 8'd0,   6'h3F},
    '{6'd55, 12'h1AA, 8'd0, 1'b0, 8'd0,   6'h3D},
    '{6'd41, 12'h1AA, 8'd0, 1'b0, 8'd0,   6'h3C},
    '{6'd2,  12'h1AA, 8'd0, 1'b1, 8'd0,   6'h3B},
    '{6'd3,  12'h1AA, 8'd0, 1'b1, 8'd0,   6'h3A},
    '{6'd9,  12'h1AA, 8'd0, 1'b1, 8'd0,   6'h35},
    '{6'd7,  12'h1AA, 8'd0, 1'b1, 8'd0,   6'h2C},
    '{6'h3F, 12'h1AA, 8'd0, 1'b1, 8'd255, 6'h2B}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic cmd_valid_o;
  logic [5:0] cmd_idx_o;
  logic [31:0] cmd_arg_o;
  logic [2:0] cmd_rsp_o;
  logic cmd_done_i = 1'b0;
  logic cmd_err_i = 1'b0;
  logic [127:0] cmd_rsp_data_i = '0;
  logic card_busy_i = 1'b0;
  logic [10:0] clk_div_o;
  logic done_o;
  logic [5:0] err_code_o;
  logic [15:0] rca_o;
  logic hc_o;
  logic [127:0] cid_o, csd_o;

  always #2 clk = ~clk;

  sd_ident_seq #(.IDLE_WAIT_CYC(IDLE_W), .INIT_TMO_CYC(INIT_T), .BUSY_TMO_CYC(BUSY_T)) u_sd_ident_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .cmd_valid_o(cmd_valid_o), .cmd_idx_o(cmd_idx_o), .cmd_arg_o(cmd_arg_o), .cmd_rsp_o(cmd_rsp_o),
    .cmd_done_i(cmd_done_i), .cmd_err_i(cmd_err_i), .cmd_rsp_data_i(cmd_rsp_data_i),
    .card_busy_i(card_busy_i), .clk_div_o(clk_div_o), .done_o(done_o), .err_code_o(err_code_o),
    .rca_o(rca_o), .hc_o(hc_o), .cid_o(cid_o), .csd_o(csd_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scenario state for the engine model
  vec_t sc;
  int cyc = 0;
  int lat = 0;
  int busy_left = 0;
  int acmd_cnt, cmd0_cnt, done_cnt;
  int t_cmd0_done, t_probe_done;
  logic [5:0] pidx;
  logic [5:0] prev_idx;
  bit seen_cid, seen_csd_req, exp_v2;

  always @(posedge clk) cyc++;

  function automatic logic [2:0] kind_of(logic [5:0] i);
    case (i)
      6'd0: return 3'd0;  6'd8: return 3'd6;  6'd55: return 3'd1; 6'd41: return 3'd4;
      6'd2: return 3'd3;  6'd3: return 3'd5;  6'd9: return 3'd3;  default: return 3'd2;
    endcase
  endfunction

  function automatic string tag_of(logic [5:0] i);
    case (i)
      6'd0: return "R2";  6'd8: return "R3";  6'd55, 6'd41: return "R4";
      6'd2: return "R8";  6'd3: return "R9";  6'd9: return "R10"; default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] arg_of(logic [5:0] i, bit v2);
    case (i)
      6'd8:        return 32'h1AA;
      6'd41:       return 32'h00FF8000 | (v2 ? 32'h4000_0000 : 32'h0);
      6'd9, 6'd7:  return {RCA_V, 16'h0};
      default:     return 32'h0;
    endcase
  endfunction

  function automatic bit order_ok(logic [5:0] p, logic [5:0] i);
    case (p)
      6'h3F: return i == 6'd0;
      6'd0:  return i == 6'd8;
      6'd8:  return i == 6'd55;
      6'd55: return i == 6'd41;
      6'd41: return (i == 6'd55) || (i == 6'd2);
      6'd2:  return i == 6'd3;
      6'd3:  return i == 6'd9;
      6'd9:  return i == 6'd7;
      default: return 1'b0;
    endcase
  endfunction

  // Command engine and card model, driven on the falling edge
  always @(negedge clk) begin
    cmd_done_i = 1'b0;
    cmd_err_i = 1'b0;
    if (done_o) done_cnt++;
    if (busy_left > 0 && sc.busy != 8'd255) begin
      busy_left--;
      if (busy_left == 0) card_busy_i = 1'b0;
    end
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        cmd_done_i = 1'b1;
        cmd_rsp_data_i = '0;
        if (pidx == sc.fail) cmd_err_i = 1'b1;
        else begin
          case (pidx)
            6'd8:  cmd_rsp_data_i = {116'h0, sc.echo};
            6'd41: begin
              if (sc.nready == 8'd255 || acmd_cnt <= int'(sc.nready)) cmd_rsp_data_i = {96'h0, 32'h00FF8000};
              else cmd_rsp_data_i = {96'h0, 1'b1, sc.ocr30, 30'h00FF8000};
            end
            6'd2:  cmd_rsp_data_i = CID_PAT;
            6'd3:  cmd_rsp_data_i = {96'h0, RCA_V, 16'h0520};
            6'd9:  cmd_rsp_data_i = CSD_PAT;
            6'd7:  begin
              cmd_rsp_data_i = {96'h0, 32'h0000_0900};
              if (sc.busy != 8'd0) begin card_busy_i = 1'b1; busy_left = int'(sc.busy); end
            end
            default: ;
          endcase
        end
        if (pidx == 6'd0) t_cmd0_done = cyc;
        if (pidx == 6'd8) t_probe_done = cyc;
      end
    end else if (cmd_valid_o) begin
      chk(order_ok(prev_idx, cmd_idx_o), tag_of(cmd_idx_o), {122'h0, cmd_idx_o}, {122'h0, prev_idx});
      chk(cmd_rsp_o == kind_of(cmd_idx_o), tag_of(cmd_idx_o), {125'h0, cmd_rsp_o}, {125'h0, kind_of(cmd_idx_o)});
      chk(cmd_arg_o == arg_of(cmd_idx_o, exp_v2), tag_of(cmd_idx_o), {96'h0, cmd_arg_o}, {96'h0, arg_of(cmd_idx_o, exp_v2)});
      if (cmd_idx_o == 6'd8)
        chk(cyc - t_cmd0_done >= IDLE_W + 1, "R2 settle gap", 128'(cyc - t_cmd0_done), 128'(IDLE_W + 1));
      if (cmd_idx_o == 6'd3) chk(clk_div_o == 11'h07D, "R9 slow before rca", {117'h0, clk_div_o}, 128'h7D);
      if (cmd_idx_o == 6'd9) chk(clk_div_o == 11'h001, "R9 fast after rca", {117'h0, clk_div_o}, 128'h1);
      if (cmd_idx_o == 6'd0) cmd0_cnt++;
      if (cmd_idx_o == 6'd41) acmd_cnt++;
      if (cmd_idx_o == 6'd2) seen_cid = 1;
      if (cmd_idx_o == 6'd9) seen_csd_req = 1;
      prev_idx = cmd_idx_o;
      pidx = cmd_idx_o;
      lat = 3;
    end
  end

  task automatic setup(input vec_t v);
    sc = v;
    acmd_cnt = 0; cmd0_cnt = 0; done_cnt = 0;
    prev_idx = 6'h3F; seen_cid = 0; seen_csd_req = 0;
    card_busy_i = 1'b0; busy_left = 0;
    exp_v2 = (v.fail != 6'd8) && (v.echo == 12'h1AA);
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_end();
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (done_cnt != 0 || err_code_o != 6'h00) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_result(input vec_t v, input int n);
    string tg;
    case (v.exp_err)
      6'h00: tg = "R12"; 6'h3F: tg = "R2"; 6'h3D, 6'h3C: tg = "R6"; 6'h3B: tg = "R8";
      6'h3A: tg = "R9"; 6'h35: tg = "R10"; 6'h2C: tg = "R11"; 6'h2B: tg = "R12"; default: tg = "R5";
    endcase
    chk(err_code_o == v.exp_err, $sformatf("%s vec %0d err", tg, n), {122'h0, err_code_o}, {122'h0, v.exp_err});
    if (v.exp_err == 6'h00) begin
      chk(done_cnt == 1, $sformatf("R12 vec %0d done pulses", n), 128'(done_cnt), 128'd1);
      chk(rca_o == RCA_V, "R9 rca", {112'h0, rca_o}, {112'h0, RCA_V});
      chk(hc_o == v.ocr30, "R7 hc", {127'h0, hc_o}, {127'h0, v.ocr30});
      chk(cid_o == CID_PAT, "R8 cid", cid_o, CID_PAT);
      chk(csd_o == CSD_PAT, "R10 csd", csd_o, CSD_PAT);
      chk(clk_div_o == 11'h001, "R9 final div", {117'h0, clk_div_o}, 128'h1);
      chk(acmd_cnt == int'(v.nready) + 1, "R4 poll count", 128'(acmd_cnt), 128'(int'(v.nready) + 1));
    end else begin
      chk(done_cnt == 0, $sformatf("R12 vec %0d no done on abort", n), 128'(done_cnt), 128'd0);
      if (v.exp_err != 6'h35 && v.exp_err != 6'h2C && v.exp_err != 6'h2B)
        chk(clk_div_o == 11'h07D, "R9 div stays slow", {117'h0, clk_div_o}, 128'h7D);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cmd_valid_o == 0 && done_o == 0, "R1 idle outputs", {126'h0, cmd_valid_o, done_o}, 128'h0);
    chk(err_code_o == 0, "R1 err", {122'h0, err_code_o}, 128'h0);
    chk(clk_div_o == 11'h07D, "R1 div", {117'h0, clk_div_o}, 128'h7D);
    chk(rca_o == 0 && hc_o == 0, "R1 rca/hc", {111'h0, rca_o, hc_o}, 128'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cmd_valid_o == 0, "R1 no request without start", {127'h0, cmd_valid_o}, 128'h0);

    for (int i = 0; i < NV; i++) begin
      setup(VECS[i]);
      pulse_start();
      wait_end();
      check_result(VECS[i], i);
    end

    // R5: card never ready, deadline from probe completion
    setup('{6'h3F, 12'h1AA, 8'd255, 1'b0, 8'd0, 6'h3E});
    pulse_start();
    wait_end();
    chk(err_code_o == 6'h3E, "R5 loop deadline code", {122'h0, err_code_o}, 128'h3E);
    chk(!seen_cid, "R5 no identity read after deadline", {127'h0, seen_cid}, 128'h0);
    chk(cyc - t_probe_done >= INIT_T, "R5 deadline not early", 128'(cyc - t_probe_done), 128'(INIT_T));
    chk(acmd_cnt >= 2, "R4 repeated polling", 128'(acmd_cnt), 128'd2);

    // R13: start during a run is ignored
    setup(VECS[0]);
    pulse_start();
    for (int k = 0; k < 2000 && !seen_csd_req; k++) @(negedge clk);
    pulse_start();
    wait_end();
    chk(cmd0_cnt == 1, "R13 single reset command", 128'(cmd0_cnt), 128'd1);
    chk(err_code_o == 6'h00 && done_cnt == 1, "R13 run completes", {122'h0, err_code_o}, 128'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule